// File: doc/BRIEF.md
# Two-Level Row Word-Line Decoder with Block Gating

This block turns a 10-bit row address into a single active word line inside a memory split into several blocks. Decoding runs in two stages. First, each adjacent pair of address bits is expanded into a four-line one-hot group. Then every row line is formed by ANDing one line from each group.

A separate block-address field drives a global select that picks exactly one block. Row lines reach the local word lines of that block only. Every other block raises a power-save flag so that its array periphery can idle.

Chip select and an enable strobe together qualify each access. When either one is low, the decoder drives no line and reports every block idle. All outputs come from registers, so a word line changes only at a clock edge and never shows two rows at once during an address change.

Top module: `hier_wl_decoder`

## Requirements
- R1: While `rst_n` is low, the next clock edge clears `pd_bus`, `blk_gsel` and `local_wl`, and sets every bit of `blk_psave`.
- R2: In an active access, group g of `pd_bus` is bits [4g+3:4g] and encodes row-address bits [2g+1:2g]. Within that group, bit 4g+v is the only high bit, where v is the value of the pair.
- R3: In an active access, exactly one bit of `local_wl` is high: bit b*1024+r, where b is `blk_addr` and r is `row_addr`.
- R4: In an active access, bit b of `blk_gsel` is high and all its other bits are low, where b is `blk_addr`.
- R5: In an active access, `blk_psave` is high for every block except block b, and low for block b.
- R6: An access is active only when both `cs` and `en` are high. Otherwise the next edge drives `pd_bus`, `blk_gsel` and `local_wl` all low and sets all `blk_psave` bits, whatever the address inputs are.
- R7: Inputs are sampled at a rising edge and take effect on the outputs right after that edge. Between edges, the outputs keep their values even if the inputs change.
- R8: At most one bit of `local_wl` is high at any time.
- R9: A local word line of block b is high only while `blk_gsel[b]` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select |
| en | input | 1 | Access enable strobe |
| row_addr | input | 10 | Row address |
| blk_addr | input | 1 | Block address |
| pd_bus | output | 20 | Predecoded pair groups, four lines per pair |
| blk_gsel | output | 2 | Global block select, one-hot |
| local_wl | output | 2048 | Local word lines, block-major |
| blk_psave | output | 2 | Per-block power-save flag |

## Verification
Every output comes from one register stage. A value driven before rising edge k is therefore visible just after edge k and holds until edge k+1.

The driver applies inputs at the falling edge and queues the expected output set. The monitor samples 1 ns after each rising edge and pops one queue entry per edge, so each comparison lines up with exactly one register delay.

For R7, a directed check reads the outputs just after new inputs are driven, before the next rising edge, and confirms that they still show the previous access.

// File: rtl/hwl_pkg.sv
package hwl_pkg;
    localparam int GRP_LINES = 4;

    function automatic logic [GRP_LINES-1:0] pair_onehot(input logic [1:0] v);
        logic [GRP_LINES-1:0] r;
        r = '0;
        r[v] = 1'b1;
        return r;
    endfunction
endpackage

// File: rtl/pair_predec.sv
module pair_predec #(
    parameter int NGRP = 5
) (
    input  logic [2*NGRP-1:0] addr,
    input  logic              act,
    output logic [4*NGRP-1:0] pd
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign pd[4*g +: 4] = act ? hwl_pkg::pair_onehot(addr[2*g +: 2]) : 4'b0000;
    end
endmodule

// File: rtl/row_and.sv
module row_and #(
    parameter int NGRP = 5,
    localparam int NROW = 1 << (2*NGRP)
) (
    input  logic [4*NGRP-1:0] pd,
    output logic [NROW-1:0]   row
);
    always_comb begin
        for (int i = 0; i < NROW; i++) begin
            logic v;
            v = 1'b1;
            for (int g = 0; g < NGRP; g++) begin
                v = v & pd[4*g + ((i >> (2*g)) & 3)];
            end
            row[i] = v;
        end
    end
endmodule

// File: rtl/blk_sel.sv
module blk_sel #(
    parameter int BLK_W = 1,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic [BLK_W-1:0] blk,
    input  logic             act,
    output logic [NBLK-1:0]  gsel,
    output logic [NBLK-1:0]  psave
);
    always_comb begin
        gsel = '0;
        if (act) gsel[blk] = 1'b1;
        psave = ~gsel;
    end
endmodule

// File: rtl/hier_wl_decoder.sv
module hier_wl_decoder #(
    parameter int ROW_W = 10,
    parameter int BLK_W = 1,
    localparam int NGRP = ROW_W / 2,
    localparam int PD_W = 4 * NGRP,
    localparam int NROW = 1 << ROW_W,
    localparam int NBLK = 1 << BLK_W,
    localparam int WL_W = NBLK * NROW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs,
    input  logic             en,
    input  logic [ROW_W-1:0] row_addr,
    input  logic [BLK_W-1:0] blk_addr,
    output logic [PD_W-1:0]  pd_bus,
    output logic [NBLK-1:0]  blk_gsel,
    output logic [WL_W-1:0]  local_wl,
    output logic [NBLK-1:0]  blk_psave
);
    typedef struct packed {
        logic [PD_W-1:0] pd;
        logic [NBLK-1:0] gsel;
        logic [WL_W-1:0] wl;
        logic [NBLK-1:0] psave;
    } dec_state_t;

    dec_state_t st_d, st_q;
    logic       act_d;
    logic [PD_W-1:0] pd_d;
    logic [NROW-1:0] row_d;
    logic [NBLK-1:0] gsel_d, psave_d;

    assign act_d = cs & en;

    pair_predec #(.NGRP(NGRP)) u_pre (.addr(row_addr), .act(act_d), .pd(pd_d));
    row_and     #(.NGRP(NGRP)) u_row (.pd(pd_d), .row(row_d));
    blk_sel     #(.BLK_W(BLK_W)) u_blk (.blk(blk_addr), .act(act_d),
                                        .gsel(gsel_d), .psave(psave_d));

    always_comb begin
        st_d.pd    = pd_d;
        st_d.gsel  = gsel_d;
        st_d.psave = psave_d;
        for (int b = 0; b < NBLK; b++) begin
            st_d.wl[b*NROW +: NROW] = row_d & {NROW{gsel_d[b]}};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pd    <= '0;
            st_q.gsel  <= '0;
            st_q.wl    <= '0;
            st_q.psave <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pd_bus    = st_q.pd;
    assign blk_gsel  = st_q.gsel;
    assign local_wl  = st_q.wl;
    assign blk_psave = st_q.psave;

    assert_wl_onehot0_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(local_wl));

    assert_gsel_onehot0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_gsel));

    assert_idle_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && en) |=> (local_wl == '0 && blk_gsel == '0 && blk_psave == '1));

    assert_active_one_wl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs && en) |=> ($countones(local_wl) == 1));

    for (genvar b = 0; b < NBLK; b++) begin : g_chk
        assert_wl_in_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (|local_wl[b*NROW +: NROW]) |-> blk_gsel[b]);
        assert_psave_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
            blk_gsel[b] |-> !blk_psave[b]);
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_pchk
        assert_pd_onehot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(pd_bus[4*g +: 4]));
    end
endmodule

// File: tb/sim_hier_wl_decoder.sv
module sim_hier_wl_decoder;
    localparam int ROW_W = 10;
    localparam int BLK_W = 1;
    localparam int NGRP  = ROW_W / 2;
    localparam int PD_W  = 4 * NGRP;
    localparam int NROW  = 1 << ROW_W;
    localparam int NBLK  = 1 << BLK_W;
    localparam int WL_W  = NBLK * NROW;

    typedef struct {
        logic       act;
        int         row;
        int         blk;
    } exp_t;

    logic clk = 0;
    logic rst_n = 0;
    logic cs = 0, en = 0;
    logic [ROW_W-1:0] row_addr = '0;
    logic [BLK_W-1:0] blk_addr = '0;
    logic [PD_W-1:0]  pd_bus;
    logic [NBLK-1:0]  blk_gsel;
    logic [WL_W-1:0]  local_wl;
    logic [NBLK-1:0]  blk_psave;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic mon_on = 0;
    exp_t q[$];
    exp_t last_exp;

    always #2.5 clk = ~clk;

    hier_wl_decoder #(.ROW_W(ROW_W), .BLK_W(BLK_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cs(cs), .en(en),
        .row_addr(row_addr), .blk_addr(blk_addr),
        .pd_bus(pd_bus), .blk_gsel(blk_gsel),
        .local_wl(local_wl), .blk_psave(blk_psave)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act_v, input longint exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act_v, exp_v);
        end
    endtask

    function automatic int first_wl();
        for (int i = 0; i < WL_W; i++) if (local_wl[i]) return i;
        return -1;
    endfunction

    task automatic compare(input exp_t e);
        logic [PD_W-1:0] epd;
        logic [NBLK-1:0] egs;
        int widx;
        epd = '0;
        egs = '0;
        widx = -1;
        if (e.act) begin
            for (int g = 0; g < NGRP; g++) epd[4*g + ((e.row >> (2*g)) & 3)] = 1'b1;
            egs[e.blk] = 1'b1;
            widx = e.blk * NROW + e.row;
        end
        check(pd_bus == epd, e.act ? "R2" : "R6", "pd_bus", longint'(pd_bus), longint'(epd));
        check(blk_gsel == egs, e.act ? "R4" : "R6", "blk_gsel", longint'(blk_gsel), longint'(egs));
        check(blk_psave == ~egs, e.act ? "R5" : "R6", "blk_psave", longint'(blk_psave), longint'(~egs));
        check($countones(local_wl) == (e.act ? 1 : 0) && first_wl() == widx,
              e.act ? "R3" : "R6", "local_wl index", longint'(first_wl()), longint'(widx));
    endtask

    task automatic drive(input logic c, input logic e, input int row, input int blk);
        @(negedge clk);
        cs = c;
        en = e;
        row_addr = ROW_W'(row);
        blk_addr = BLK_W'(blk);
        q.push_back('{act: c & e, row: row, blk: blk});
    endtask

    always begin
        @(posedge clk);
        #1;
        if (mon_on && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            compare(e);
            last_exp = e;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<20000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cs = 1; en = 1; row_addr = 10'h3FF; blk_addr = 1;
        repeat (3) @(posedge clk);
        #1;
        check(pd_bus == '0 && blk_gsel == '0, "R1", "reset pd/gsel",
              longint'(blk_gsel), 0);
        check(local_wl == '0, "R1", "reset wl count", $countones(local_wl), 0);
        check(blk_psave == '1, "R1", "reset psave", longint'(blk_psave), 3);
        @(negedge clk);
        rst_n = 1;
        cs = 0; en = 0;
        mon_on = 1;

        drive(1, 1, 0, 0);
        drive(1, 1, 1023, 0);
        drive(1, 1, 1023, 1);
        drive(1, 1, 0, 1);
        drive(1, 1, 'h155, 0);
        drive(1, 1, 'h2AA, 1);
        drive(1, 1, 'h2AA, 0);
        drive(0, 1, 'h123, 1);
        drive(1, 0, 'h321, 0);
        drive(0, 0, 'h3FF, 1);
        drive(1, 1, 'h0F0, 1);
        drive(1, 1, 'h00F, 1);

        // R7: new inputs are not visible before the next rising edge
        drive(1, 1, 'h1A5, 0);
        #1;
        check(first_wl() == NROW + 'h00F, "R7", "wl held between edges",
              longint'(first_wl()), NROW + 'h00F);
        row_addr = 10'h001;
        #0.5;
        check(first_wl() == NROW + 'h00F, "R7", "wl ignores mid-cycle input",
              longint'(first_wl()), NROW + 'h00F);
        row_addr = 10'h1A5;

        for (int k = 0; k < 300; k++) begin
            int r, b, sel;
            r = int'($urandom_range(0, NROW - 1));
            b = int'($urandom_range(0, NBLK - 1));
            sel = int'($urandom_range(0, 7));
            drive(sel != 0, sel != 1, r, b);
        end

        drive(0, 0, 0, 0);
        repeat (3) @(posedge clk);
        #2;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule